// File: doc/BRIEF.md
# Power Management Register File

This block is a word-addressed register file for a power-management unit. Software reaches it over a simple bus with a byte address, separate read and write strobes, 32-bit data and an error flag. The space holds 64 words. Most words are ordinary read/write storage. A few words follow special write rules:
- a control word whose bits can only be set,
- three status words that are cleared by writing ones,
- a scratch word that also serves as the resume address.

A second port takes power-mode commands, such as those issued by a processor's coprocessor path. The low three bits of a command choose the mode. Idle, deep idle and standby each raise a one-cycle halt request. Deep idle and standby also set status bits in the register file as a side effect, and standby loads the scratch word onto the resume-address output. A sticky flag records any command that asks for a voltage change. An external input reports whether the core is clock-disabled, and this changes how idle is handled.

Top module: `pwr_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register to zero. After reset, reads return zero, and halt_req, volt_flag and resume_addr are all zero.
- R2: An access is an error when its address has bit 1 or bit 0 set, or when the address is above 0xFC. For an error access, bus_err is 1 in the cycle after the strobe, read data is zero, and a write changes no register.
- R3: The word at 0x00 keeps only bits 0, 2 and 4 (mask 0x15). Writing 1 to one of these bits sets it, and writing 0 leaves it as it is. All other bits read 0.
- R4: The words at 0x04 (sleep status), 0x30 (reset status) and 0x54 (keyboard status) are write-one-to-clear. Each bit written as 1 is cleared, and each bit written as 0 is kept.
- R5: Every other aligned word from 0x00 to 0xFC, scratch 0x08 included, stores the whole written value. Read data appears in the cycle after the read strobe and is zero in every other cycle.
- R6: Command mode 1 (idle) with core_dis at 0 raises halt_req and changes no status bit.
- R7: Command mode 2 (deep idle) raises halt_req and sets bit 3 of 0x30. Mode 1 with core_dis at 1 does exactly the same.
- R8: Command mode 3 (standby) sets bit 3 of 0x04 and bit 3 of 0x30, raises halt_req, and loads resume_addr with the value held at 0x08.
- R9: Command modes 0, 4, 5, 6 and 7 raise no halt and change no register.
- R10: halt_req is high for exactly the one cycle that follows the cycle in which the command was accepted.
- R11: A command with bit 3 set raises volt_flag, whatever its mode. volt_flag then stays high until reset.
- R12: A bus write-one-to-clear and a command status set may hit the same bit in the same cycle. When they do, the set wins and the bit reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, one cycle after the read strobe |
| bus_err | output | 1 | Error response, one cycle after the strobe |
| mode_valid | input | 1 | Power-mode command strobe |
| mode_cmd | input | 4 | Mode in bits 2:0, voltage-change request in bit 3 |
| core_dis | input | 1 | Core clock-disable state, from the clock configuration |
| halt_req | output | 1 | One-cycle halt request |
| resume_addr | output | DW | Resume address, captured from 0x08 on standby |
| volt_flag | output | 1 | Sticky voltage-change-attempt flag |

## Verification
A wrong status word stays hidden until software reads it back. It then shows as a wrong read value one cycle after the read strobe, so every command test is followed at once by reads of 0x04 and 0x30. A decode error that sends a write to the wrong word is caught by reading the words it could have reached. A fault in the halt logic appears on halt_req in the first cycle after the command, or as a pulse that lasts one cycle too long. A wrong resume address is visible on the same edge as the halt pulse.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  // Kinds of word in the register space.
  typedef enum logic [2:0] {
    K_PLAIN, K_CTRL, K_SLEEP, K_RSTS, K_KBD, K_SCRATCH
  } reg_kind_t;

  // Power-mode codes carried in command bits 2:0.
  typedef enum logic [2:0] {
    M_NONE = 3'd0, M_IDLE = 3'd1, M_DEEP = 3'd2, M_STBY = 3'd3,
    M_SLEEP = 3'd4, M_RSV5 = 3'd5, M_RSV6 = 3'd6, M_DSLEEP = 3'd7
  } pmode_t;

  // Word indices of the special words.
  localparam int IDX_CTRL    = 0;
  localparam int IDX_SLEEP   = 1;
  localparam int IDX_SCRATCH = 2;
  localparam int IDX_RSTS    = 12;
  localparam int IDX_KBD     = 21;

  localparam logic [31:0] CTRL_MASK = 32'h0000_0015;
  localparam int          STS_BIT   = 3;
  localparam int          VOLT_BIT  = 3;
endpackage

// File: rtl/pwr_addr_dec.sv
module pwr_addr_dec
  import pwr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NWORDS = 64,
  parameter int IDX_W  = $clog2(NWORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              ok,
  output logic [IDX_W-1:0]  idx,
  output reg_kind_t         kind
);
  localparam int TOP_BYTE = NWORDS * 4;

  always_comb begin
    ok  = (addr[1:0] == 2'b00) && (addr < ADDR_W'(TOP_BYTE));
    idx = addr[IDX_W+1:2];
    if      (int'(idx) == IDX_CTRL)    kind = K_CTRL;
    else if (int'(idx) == IDX_SLEEP)   kind = K_SLEEP;
    else if (int'(idx) == IDX_SCRATCH) kind = K_SCRATCH;
    else if (int'(idx) == IDX_RSTS)    kind = K_RSTS;
    else if (int'(idx) == IDX_KBD)     kind = K_KBD;
    else                               kind = K_PLAIN;
  end
endmodule

// File: rtl/pwr_word_ram.sv
module pwr_word_ram #(
  parameter int DW     = 32,
  parameter int NWORDS = 64,
  parameter int IDX_W  = $clog2(NWORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [DW-1:0]    wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] ridx,
  output logic [DW-1:0]    rdata
);
  // The array has no reset, so it can map to block RAM.
  // A per-word written flag makes unwritten words read as zero after reset.
  logic [DW-1:0]     mem [NWORDS];
  logic [NWORDS-1:0] written;
  logic [DW-1:0]     rd_q;
  logic              hit_q;

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    rd_q <= mem[ridx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written <= '0;
      hit_q   <= 1'b0;
    end else begin
      if (we) written[widx] <= 1'b1;
      hit_q <= re && written[ridx];
    end
  end

  assign rdata = hit_q ? rd_q : '0;
endmodule

// File: rtl/pwr_special_regs.sv
module pwr_special_regs
  import pwr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  reg_kind_t     kind,
  input  logic [DW-1:0] wdata,
  input  logic          set_sleep,
  input  logic          set_rsts,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] sleep_q,
  output logic [DW-1:0] rsts_q,
  output logic [DW-1:0] kbd_q,
  output logic [DW-1:0] scratch_q
);
  logic [DW-1:0] ctrl_n, sleep_n, rsts_n, kbd_n, scratch_n;

  always_comb begin
    ctrl_n    = ctrl_q;
    sleep_n   = sleep_q;
    rsts_n    = rsts_q;
    kbd_n     = kbd_q;
    scratch_n = scratch_q;
    if (we) begin
      unique case (kind)
        K_CTRL:    ctrl_n    = ctrl_q | (wdata & DW'(CTRL_MASK));
        K_SLEEP:   sleep_n   = sleep_q & ~wdata;
        K_RSTS:    rsts_n    = rsts_q & ~wdata;
        K_KBD:     kbd_n     = kbd_q & ~wdata;
        K_SCRATCH: scratch_n = wdata;
        default:   ;
      endcase
    end
    // A status set from a command is applied after the bus clear, so the set wins.
    if (set_sleep) sleep_n[STS_BIT] = 1'b1;
    if (set_rsts)  rsts_n[STS_BIT]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      sleep_q   <= '0;
      rsts_q    <= '0;
      kbd_q     <= '0;
      scratch_q <= '0;
    end else begin
      ctrl_q    <= ctrl_n;
      sleep_q   <= sleep_n;
      rsts_q    <= rsts_n;
      kbd_q     <= kbd_n;
      scratch_q <= scratch_n;
    end
  end
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pwr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_valid,
  input  logic [3:0]    mode_cmd,
  input  logic          core_dis,
  input  logic [DW-1:0] scratch,
  output logic          set_sleep,
  output logic          set_rsts,
  output logic          halt_req,
  output logic [DW-1:0] resume_addr,
  output logic          volt_flag
);
  pmode_t mode;
  logic   halt_n, load_resume;

  always_comb begin
    mode        = pmode_t'(mode_cmd[2:0]);
    halt_n      = 1'b0;
    set_sleep   = 1'b0;
    set_rsts    = 1'b0;
    load_resume = 1'b0;
    if (mode_valid) begin
      unique case (mode)
        M_IDLE: begin
          halt_n   = 1'b1;
          set_rsts = core_dis;
        end
        M_DEEP: begin
          halt_n   = 1'b1;
          set_rsts = 1'b1;
        end
        M_STBY: begin
          halt_n      = 1'b1;
          set_rsts    = 1'b1;
          set_sleep   = 1'b1;
          load_resume = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_req    <= 1'b0;
      resume_addr <= '0;
      volt_flag   <= 1'b0;
    end else begin
      halt_req <= halt_n;
      if (load_resume) resume_addr <= scratch;
      if (mode_valid && mode_cmd[VOLT_BIT]) volt_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/pwr_regfile.sv
module pwr_regfile
  import pwr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DW     = 32,
  parameter int NWORDS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_err,
  input  logic              mode_valid,
  input  logic [3:0]        mode_cmd,
  input  logic              core_dis,
  output logic              halt_req,
  output logic [DW-1:0]     resume_addr,
  output logic              volt_flag
);
  localparam int IDX_W = $clog2(NWORDS);

  logic             a_ok;
  logic [IDX_W-1:0] a_idx;
  reg_kind_t        a_kind;
  logic             wr_ok, rd_ok;
  logic             set_sleep, set_rsts;
  logic [DW-1:0]    ctrl_q, sleep_q, rsts_q, kbd_q, scratch_q;
  logic [DW-1:0]    ram_rdata, spec_rd_q, spec_mux;
  logic             err_q;

  pwr_addr_dec #(.ADDR_W(ADDR_W), .NWORDS(NWORDS), .IDX_W(IDX_W)) u_dec (
    .addr(bus_addr), .ok(a_ok), .idx(a_idx), .kind(a_kind)
  );

  assign wr_ok = bus_wr && a_ok;
  assign rd_ok = bus_rd && a_ok;

  pwr_word_ram #(.DW(DW), .NWORDS(NWORDS), .IDX_W(IDX_W)) u_ram (
    .clk(clk), .rst(rst),
    .we(wr_ok && (a_kind == K_PLAIN)), .widx(a_idx), .wdata(bus_wdata),
    .re(rd_ok && (a_kind == K_PLAIN)), .ridx(a_idx), .rdata(ram_rdata)
  );

  pwr_mode_ctl #(.DW(DW)) u_mode (
    .clk(clk), .rst(rst), .mode_valid(mode_valid), .mode_cmd(mode_cmd),
    .core_dis(core_dis), .scratch(scratch_q), .set_sleep(set_sleep),
    .set_rsts(set_rsts), .halt_req(halt_req), .resume_addr(resume_addr),
    .volt_flag(volt_flag)
  );

  pwr_special_regs #(.DW(DW)) u_spec (
    .clk(clk), .rst(rst), .we(wr_ok), .kind(a_kind), .wdata(bus_wdata),
    .set_sleep(set_sleep), .set_rsts(set_rsts), .ctrl_q(ctrl_q),
    .sleep_q(sleep_q), .rsts_q(rsts_q), .kbd_q(kbd_q), .scratch_q(scratch_q)
  );

  always_comb begin
    unique case (a_kind)
      K_CTRL:    spec_mux = ctrl_q;
      K_SLEEP:   spec_mux = sleep_q;
      K_RSTS:    spec_mux = rsts_q;
      K_KBD:     spec_mux = kbd_q;
      K_SCRATCH: spec_mux = scratch_q;
      default:   spec_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spec_rd_q <= '0;
      err_q     <= 1'b0;
    end else begin
      spec_rd_q <= rd_ok ? spec_mux : '0;
      err_q     <= (bus_rd || bus_wr) && !a_ok;
    end
  end

  // Only one of the two read sources is nonzero in any cycle.
  assign bus_rdata = spec_rd_q | ram_rdata;
  assign bus_err   = err_q;
endmodule

// File: rtl/pwr_regfile_chk.sv
module pwr_regfile_chk #(
  parameter int ADDR_W = 12,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic [DW-1:0]     bus_rdata,
  input logic              bus_err,
  input logic              mode_valid,
  input logic [3:0]        mode_cmd,
  input logic              halt_req,
  input logic [DW-1:0]     resume_addr,
  input logic              volt_flag
);
  a_r2_err_reads_zero: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (bus_rdata == '0));

  a_r3_ctrl_only_mask: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == '0) |=> ((bus_rdata & ~DW'(32'h15)) == '0));

  a_r6_idle_halts: assert property (@(posedge clk) disable iff (rst)
    (mode_valid && mode_cmd[2:0] == 3'd1) |=> halt_req);

  a_r8_resume_only_on_standby: assert property (@(posedge clk) disable iff (rst)
    !$stable(resume_addr) |-> $past(mode_valid && mode_cmd[2:0] == 3'd3));

  a_r9_noop_no_halt: assert property (@(posedge clk) disable iff (rst)
    (mode_valid && (mode_cmd[2:0] == 3'd0 || mode_cmd[2:0] >= 3'd4)) |=> !halt_req);

  a_r10_halt_has_cause: assert property (@(posedge clk) disable iff (rst)
    halt_req |-> $past(mode_valid));

  a_r11_volt_sticky: assert property (@(posedge clk) disable iff (rst)
    volt_flag |=> volt_flag);
endmodule

bind pwr_regfile pwr_regfile_chk #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .bus_err(bus_err), .mode_valid(mode_valid),
  .mode_cmd(mode_cmd), .halt_req(halt_req), .resume_addr(resume_addr),
  .volt_flag(volt_flag)
);

// File: tb/tb_pwr_regfile.sv
module tb_pwr_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DW = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_rd = 1'b0, bus_wr = 1'b0;
  logic [DW-1:0]     bus_wdata = '0;
  logic [DW-1:0]     bus_rdata;
  logic              bus_err;
  logic              mode_valid = 1'b0;
  logic [3:0]        mode_cmd = '0;
  logic              core_dis = 1'b0;
  logic              halt_req;
  logic [DW-1:0]     resume_addr;
  logic              volt_flag;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_regfile #(.ADDR_W(ADDR_W), .DW(DW), .NWORDS(64)) dut (.*);

  task automatic check(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d, output logic e);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    e = bus_err;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DW-1:0] d, output logic e);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata; e = bus_err;
  endtask

  // Issues a command and checks the halt pulse shape (R10).
  task automatic cmd(input logic [3:0] c, input logic exp_halt);
    @(negedge clk);
    mode_cmd = c; mode_valid = 1'b1;
    @(negedge clk);
    mode_valid = 1'b0;
    check("R10 halt in cycle after command", DW'(halt_req), DW'(exp_halt));
    @(negedge clk);
    check("R10 halt lasts one cycle", DW'(halt_req), '0);
  endtask

  task automatic expect_rd(string req, input logic [ADDR_W-1:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] d; logic e;
    rd(a, d, e);
    check(req, d, exp);
    check(req, DW'(e), '0);
  endtask

  task automatic t_reset();
    expect_rd("R1 reset ctrl", 12'h000, '0);
    expect_rd("R1 reset plain", 12'h040, '0);
    expect_rd("R1 reset rsts", 12'h030, '0);
    check("R1 reset halt", DW'(halt_req), '0);
    check("R1 reset volt", DW'(volt_flag), '0);
    check("R1 reset resume", resume_addr, '0);
  endtask

  task automatic t_plain();
    logic e;
    wr(12'h040, 32'hA5A5_5A5A, e);
    wr(12'h0FC, 32'hDEAD_BEEF, e);
    wr(12'h00C, 32'h0000_0001, e);
    wr(12'h008, 32'hFFFF_0000, e);
    expect_rd("R5 plain 0x40", 12'h040, 32'hA5A5_5A5A);
    expect_rd("R5 plain 0xFC", 12'h0FC, 32'hDEAD_BEEF);
    expect_rd("R5 plain 0x0C", 12'h00C, 32'h0000_0001);
    expect_rd("R5 scratch 0x08", 12'h008, 32'hFFFF_0000);
    @(negedge clk);
    check("R5 rdata idle zero", bus_rdata, '0);
  endtask

  task automatic t_err();
    logic [DW-1:0] d; logic e;
    rd(12'h042, d, e);
    check("R2 misaligned read err", DW'(e), 1);
    check("R2 misaligned read data", d, '0);
    wr(12'h041, 32'h1111_1111, e);
    check("R2 misaligned write err", DW'(e), 1);
    expect_rd("R2 misaligned write ignored", 12'h040, 32'hA5A5_5A5A);
    wr(12'h100, 32'h0000_0015, e);
    check("R2 range write err", DW'(e), 1);
    expect_rd("R2 range write ignored", 12'h000, '0);
    wr(12'h140, 32'h2222_2222, e);
    expect_rd("R2 range write alias ignored", 12'h040, 32'hA5A5_5A5A);
    rd(12'h100, d, e);
    check("R2 range read err", DW'(e), 1);
  endtask

  task automatic t_ctrl();
    logic e;
    wr(12'h000, 32'h0000_0001, e);
    expect_rd("R3 set bit0", 12'h000, 32'h1);
    wr(12'h000, 32'h0000_0004, e);
    expect_rd("R3 set bit2 keeps bit0", 12'h000, 32'h5);
    wr(12'h000, 32'h0000_0000, e);
    expect_rd("R3 zero write no clear", 12'h000, 32'h5);
    wr(12'h000, 32'hFFFF_FFFF, e);
    expect_rd("R3 only mask bits", 12'h000, 32'h15);
  endtask

  task automatic t_idle();
    core_dis = 1'b0;
    cmd(4'd1, 1'b1);
    expect_rd("R6 idle no rsts", 12'h030, '0);
    expect_rd("R6 idle no sleep", 12'h004, '0);
    core_dis = 1'b1;
    cmd(4'd1, 1'b1);
    core_dis = 1'b0;
    expect_rd("R7 idle with core_dis sets rsts", 12'h030, 32'h8);
  endtask

  task automatic t_w1c();
    logic e;
    wr(12'h030, 32'h0000_0000, e);
    expect_rd("R4 zero keeps", 12'h030, 32'h8);
    wr(12'h030, 32'h0000_0008, e);
    expect_rd("R4 one clears", 12'h030, '0);
    wr(12'h054, 32'hFFFF_FFFF, e);
    expect_rd("R4 kbd not stored", 12'h054, '0);
    cmd(4'd2, 1'b1);
    expect_rd("R7 deep idle sets rsts", 12'h030, 32'h8);
  endtask

  task automatic t_standby();
    logic e;
    wr(12'h030, 32'hFFFF_FFFF, e);
    wr(12'h008, 32'h1234_5670, e);
    @(negedge clk);
    mode_cmd = 4'd3; mode_valid = 1'b1;
    @(negedge clk);
    mode_valid = 1'b0;
    check("R8 standby halt", DW'(halt_req), 1);
    check("R8 resume addr", resume_addr, 32'h1234_5670);
    expect_rd("R8 sleep status", 12'h004, 32'h8);
    expect_rd("R8 reset status", 12'h030, 32'h8);
  endtask

  task automatic t_noop();
    logic e;
    wr(12'h004, 32'hFFFF_FFFF, e);
    wr(12'h030, 32'hFFFF_FFFF, e);
    for (int m = 0; m < 8; m++) begin
      if (m == 0 || m >= 4) cmd(4'(m), 1'b0);
    end
    expect_rd("R9 no sleep set", 12'h004, '0);
    expect_rd("R9 no rsts set", 12'h030, '0);
    check("R9 resume kept", resume_addr, 32'h1234_5670);
  endtask

  task automatic t_volt();
    check("R11 volt low before", DW'(volt_flag), '0);
    cmd(4'b1000, 1'b0);
    check("R11 volt set", DW'(volt_flag), 1);
    cmd(4'd0, 1'b0);
    check("R11 volt sticky", DW'(volt_flag), 1);
  endtask

  task automatic t_collide();
    @(negedge clk);
    bus_addr = 12'h030; bus_wdata = 32'h0000_0008; bus_wr = 1'b1;
    mode_cmd = 4'd2; mode_valid = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; mode_valid = 1'b0;
    expect_rd("R12 set wins over clear", 12'h030, 32'h8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_plain();
    t_err();
    t_ctrl();
    t_idle();
    t_w1c();
    t_standby();
    t_noop();
    t_volt();
    t_collide();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule